// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits behind the receive line decoder. It takes a byte-wide stream that carries each frame from its first preamble byte through the last FCS byte. On that stream it marks the start of every frame, the end, and whether the CRC checker found the FCS bad. The block checks the preamble and start-of-frame delimiter and enforces a maximum frame length. It can remove the trailing FCS, or the FCS together with any padding. In passthrough mode it hands the preamble and delimiter on to the client instead of removing them.

Every option is a static configuration input, held steady while frames flow. The client sees a byte stream that carries start, end and error flags, plus an oversize flag on the end beat. A frame on the input is six preamble bytes, then the delimiter, then the body. The body runs from the destination address through the FCS, and the body alone counts toward the length limit. The strip mode input `cfg_strip` is coded as follows: 0 keeps every body byte, 1 removes the FCS, and 2 or 3 removes the FCS and the padding.

Top module: `eth_rx_frame_filter`

## Requirements
- R1: With passthrough off, only body bytes reach the output, in order. `out_sof` is set on the first delivered byte and `out_eof` on the last. In strip mode 0 each byte appears one clock after its input beat.
- R2: With `cfg_strict_pre` set, a frame is dropped if any of its six preamble bytes differs from 0x55.
- R3: With `cfg_strict_sfd` set, a frame is dropped if its delimiter byte differs from 0xD5. With both strict inputs clear, such a frame is delivered normally.
- R4: A dropped frame produces no output beats, and the next frame after it is delivered normally.
- R5: With `cfg_pass_pre` set, the six preamble bytes and the delimiter are delivered ahead of the body, and `out_sof` is on the first preamble byte. A failed strict check does not drop the frame in this mode. It sets `out_err` on the end beat instead.
- R6: With `cfg_trunc_en` clear, a body longer than `cfg_max_len` is delivered whole, with `out_oversize` set on its end beat.
- R7: With `cfg_trunc_en` set, a body longer than `cfg_max_len` is cut after `cfg_max_len` bytes. Its end beat carries both `out_oversize` and `out_err`, and the rest of the frame is discarded. A body of exactly `cfg_max_len` bytes is not oversize.
- R8: In strip mode 1, the last four body bytes are removed and `out_eof` moves to the last remaining byte. Truncation is applied first, so the four bytes are removed from the cut frame.
- R9: `in_fcs_bad` on the input end beat sets `out_err` on the delivered end beat, in every strip mode.
- R10: In strip mode 2, a Length/Type field (body bytes 12 and 13, high byte first) below 46 limits delivery to 14 plus that many bytes. A larger field value gives the same result as strip mode 1.
- R11: While reset is asserted, and until the first input beat after it, all output flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_strict_pre | input | 1 | Drop frames with a bad preamble |
| cfg_strict_sfd | input | 1 | Drop frames with a bad delimiter |
| cfg_pass_pre | input | 1 | Deliver preamble and delimiter |
| cfg_trunc_en | input | 1 | Cut frames at the length limit |
| cfg_max_len | input | LEN_W | Maximum body length in bytes |
| cfg_strip | input | 2 | Strip mode: 0 none, 1 FCS, 2/3 FCS and pad |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First preamble byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| in_fcs_bad | input | 1 | FCS bad, qualified by the end beat |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First delivered byte |
| out_eof | output | 1 | Last delivered byte |
| out_data | output | 8 | Output byte |
| out_err | output | 1 | Frame error, on the end beat |
| out_oversize | output | 1 | Body exceeded the limit, on the end beat |

## Verification
The assertions check several rules on every cycle. Output beats appear only one clock after an input beat, and flags never appear without valid. Oversize shows only on an end beat and always comes with an error when truncation is on. In strip mode 0 each output byte equals the input byte of the cycle before. Whether a frame is dropped depends on the whole header, and the positions of removed bytes depend on the length field and on the frame end. These rules, along with truncation length and padding removal, show only in the bench's frame scenarios. There each delivered byte is compared against a model of the requirements, and an empty queue after each frame confirms that no byte is missing or extra.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;

    localparam int PRE_BYTES     = 6;
    localparam int FCS_BYTES     = 4;
    localparam int MAC_HDR_BYTES = 14;
    localparam int MIN_PAYLOAD   = 46;
    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2,
        ST_SKIP = 2'd3
    } rxf_state_e;

    typedef struct packed {
        logic       vld;
        logic       sof;
        logic       eof;
        logic       err;
        logic       ovs;
        logic [7:0] data;
    } rxf_beat_t;

    function automatic rxf_beat_t mk_beat(input logic sof, input logic eof,
                                          input logic err, input logic ovs,
                                          input logic [7:0] data);
        rxf_beat_t b;
        b.vld  = 1'b1;
        b.sof  = sof;
        b.eof  = eof;
        b.err  = err;
        b.ovs  = ovs;
        b.data = data;
        return b;
    endfunction

endpackage

// File: rtl/eth_rxf_tail_delay.sv
module eth_rxf_tail_delay #(
    parameter int DW    = 8,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int LINE_W = DW * DEPTH;

    logic [LINE_W-1:0] line_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    line_q <= '0;
                else if (push) line_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    line_q <= '0;
                else if (push) line_q <= {line_q[LINE_W-DW-1:0], din};
            end
        end
    endgenerate

    // Oldest byte: the one pushed DEPTH pushes ago
    assign dout = line_q[LINE_W-1 -: DW];

endmodule

// File: rtl/eth_rxf_pad_limit.sv
module eth_rxf_pad_limit
    import eth_rxf_pkg::*;
#(
    parameter int LIM_W = 17
) (
    input  logic [7:0]       lt_hi,
    input  logic [7:0]       lt_lo,
    output logic             is_short,
    output logic [LIM_W-1:0] keep_lim
);

    logic [15:0] lt_val;

    always_comb begin
        lt_val   = {lt_hi, lt_lo};
        is_short = lt_val < 16'(MIN_PAYLOAD);
        keep_lim = LIM_W'(MAC_HDR_BYTES) + LIM_W'(lt_val);
    end

endmodule

// File: rtl/eth_rx_frame_filter.sv
module eth_rx_frame_filter
    import eth_rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_strict_pre,
    input  logic             cfg_strict_sfd,
    input  logic             cfg_pass_pre,
    input  logic             cfg_trunc_en,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic [1:0]       cfg_strip,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic             in_fcs_bad,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic [7:0]       out_data,
    output logic             out_err,
    output logic             out_oversize
);

    localparam int CNT_W = LEN_W + 1;
    localparam int DLY   = FCS_BYTES - 1;
    localparam int HC_W  = $clog2(PRE_BYTES + 2);

    typedef struct packed {
        rxf_state_e       st;
        logic [HC_W-1:0]  hdr_cnt;
        logic             hdr_bad;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] limit;
        logic [7:0]       lt_hi;
        logic             hold_vld;
        logic [7:0]       hold_data;
        logic             sof_pend;
        rxf_beat_t        out;
    } rxf_state_t;

    rxf_state_t s_d, s_q;

    logic             push;
    logic [7:0]       dl_out;
    logic             pad_short;
    logic [CNT_W-1:0] pad_lim;

    eth_rxf_tail_delay #(.DW(8), .DEPTH(DLY)) i_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .din  (in_data),
        .dout (dl_out)
    );

    eth_rxf_pad_limit #(.LIM_W(CNT_W)) i_pad (
        .lt_hi   (s_q.lt_hi),
        .lt_lo   (in_data),
        .is_short(pad_short),
        .keep_lim(pad_lim)
    );

    assign push = in_valid && !in_sof && (s_q.st == ST_BODY);

    logic [HC_W-1:0]  hc;
    logic             hbad, bad_acc, sof_p;
    logic [CNT_W-1:0] cnt;
    logic             trunc_hit, fin, ovs, err, strip_on, pad_on;

    always_comb begin
        s_d       = s_q;
        s_d.out   = '0;
        strip_on  = (cfg_strip != 2'd0);
        pad_on    = cfg_strip[1];
        hc        = in_sof ? '0 : s_q.hdr_cnt;
        hbad      = (hc < HC_W'(PRE_BYTES)) ? (cfg_strict_pre && in_data != PRE_BYTE)
                                            : (cfg_strict_sfd && in_data != SFD_BYTE);
        bad_acc   = (!in_sof && s_q.hdr_bad) || hbad;
        sof_p     = in_sof || s_q.sof_pend;
        cnt       = (&s_q.idx) ? s_q.idx : s_q.idx + 1'b1;
        trunc_hit = cfg_trunc_en && !in_eof && (cnt == {1'b0, cfg_max_len});
        fin       = in_eof || trunc_hit;
        ovs       = trunc_hit || (cnt > {1'b0, cfg_max_len});
        err       = (in_eof && in_fcs_bad) || trunc_hit || s_q.hdr_bad;

        if (in_valid) begin
            if (in_sof || s_q.st == ST_HDR) begin
                s_d.hdr_bad  = bad_acc;
                s_d.sof_pend = sof_p;
                s_d.hdr_cnt  = hc + 1'b1;
                if (cfg_pass_pre) begin
                    s_d.out      = mk_beat(sof_p, in_eof, in_eof, 1'b0, in_data);
                    s_d.sof_pend = 1'b0;
                end
                if (in_eof) begin
                    s_d.st = ST_IDLE;
                end else if (hc == HC_W'(PRE_BYTES)) begin
                    s_d.st       = (bad_acc && !cfg_pass_pre) ? ST_SKIP : ST_BODY;
                    s_d.idx      = '0;
                    s_d.limit    = '1;
                    s_d.hold_vld = 1'b0;
                end else begin
                    s_d.st = ST_HDR;
                end
            end else if (s_q.st == ST_BODY) begin
                if (!strip_on) begin
                    s_d.out      = mk_beat(s_q.sof_pend, fin, fin && err, fin && ovs, in_data);
                    s_d.sof_pend = 1'b0;
                end else if (fin) begin
                    if (s_q.hold_vld) begin
                        s_d.out      = mk_beat(s_q.sof_pend, 1'b1, err, ovs, s_q.hold_data);
                        s_d.sof_pend = 1'b0;
                    end
                    s_d.hold_vld = 1'b0;
                end else if (s_q.idx >= CNT_W'(DLY) &&
                             (s_q.idx - CNT_W'(DLY)) < s_q.limit) begin
                    if (s_q.hold_vld) begin
                        s_d.out      = mk_beat(s_q.sof_pend, 1'b0, 1'b0, 1'b0, s_q.hold_data);
                        s_d.sof_pend = 1'b0;
                    end
                    s_d.hold_data = dl_out;
                    s_d.hold_vld  = 1'b1;
                end
                if (s_q.idx == CNT_W'(12)) s_d.lt_hi = in_data;
                if (s_q.idx == CNT_W'(13) && pad_on && pad_short) s_d.limit = pad_lim;
                s_d.idx = cnt;
                if (fin) s_d.st = in_eof ? ST_IDLE : ST_SKIP;
            end else if (s_q.st == ST_SKIP && in_eof) begin
                s_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid    = s_q.out.vld;
    assign out_sof      = s_q.out.sof;
    assign out_eof      = s_q.out.eof;
    assign out_err      = s_q.out.err;
    assign out_oversize = s_q.out.ovs;
    assign out_data     = s_q.out.data;

endmodule

// File: rtl/eth_rxf_checker.sv
module eth_rxf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic [1:0] cfg_strip,
    input logic       cfg_trunc_en,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic       out_err,
    input logic       out_oversize,
    input logic [7:0] out_data
);

    // R1: every output beat follows an input beat by one clock
    p_emit_after_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R1: flags are qualified by valid
    p_flags_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof || out_err || out_oversize) |-> out_valid);

    // R6: oversize only on an end beat
    p_oversize_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_oversize |-> out_eof);

    // R7: a truncated frame also carries an error
    p_trunc_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_oversize && cfg_trunc_en) |-> out_err);

    // R1: without stripping, the byte is the one from the previous cycle
    p_plain_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_strip == 2'd0 && $past(cfg_strip) == 2'd0)
            |-> out_data == $past(in_data));

endmodule

bind eth_rx_frame_filter eth_rxf_checker i_chk (.*);

// File: tb/test_eth_rx_frame_filter.sv
module test_eth_rx_frame_filter;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       eof;
        logic       err;
        logic       ovs;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_strict_pre = 1'b0, cfg_strict_sfd = 1'b0, cfg_pass_pre = 1'b0;
    logic        cfg_trunc_en = 1'b0;
    logic [15:0] cfg_max_len = 16'd1518;
    logic [1:0]  cfg_strip = 2'd0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_fcs_bad = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        out_valid, out_sof, out_eof, out_err, out_oversize;
    logic [7:0]  out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";
    exp_t  exp_q[$];
    string req_q[$];
    logic [7:0] hdr_b[7];
    logic [7:0] body[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rx_frame_filter i_eth_rx_frame_filter (.*);

    // Monitor: compares each delivered beat with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected beat d=%h eof=%b, expected no output", cur_req, out_data, out_eof);
            end else begin
                exp_t e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if ({out_data, out_sof, out_eof, out_err, out_oversize} != e) begin
                    fails++;
                    $display("FAIL %s: got d=%h sof=%b eof=%b err=%b ovs=%b, expected d=%h sof=%b eof=%b err=%b ovs=%b",
                             r, out_data, out_sof, out_eof, out_err, out_oversize,
                             e.data, e.sof, e.eof, e.err, e.ovs);
                end
            end
        end
    end

    task automatic make_frame(input int len, input logic [15:0] lt);
        for (int i = 0; i < 6; i++) hdr_b[i] = 8'h55;
        hdr_b[6] = 8'hD5;
        body.delete();
        for (int i = 0; i < len; i++) body.push_back(8'((i * 7 + 3) & 8'hFF));
        body[12] = lt[15:8];
        body[13] = lt[7:0];
    endtask

    task automatic drive(input logic [7:0] d, input bit s, input bit e, input bit fb);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_fcs_bad = fb;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_fcs_bad = 1'b0;
        end
    endtask

    task automatic run_frame(input string req, input bit fb, input int gap);
        bit hb, th, ov, er;
        int n, eff, keep, ln, mx, k;
        logic [7:0] lst[$];
        cur_req = req;
        hb = 0;
        for (int i = 0; i < 6; i++) if (cfg_strict_pre && hdr_b[i] != 8'h55) hb = 1;
        if (cfg_strict_sfd && hdr_b[6] != 8'hD5) hb = 1;
        n    = body.size();
        mx   = int'(cfg_max_len);
        th   = cfg_trunc_en && n > mx;
        eff  = th ? mx : n;
        ov   = n > mx;
        er   = (fb && !th) || th || (cfg_pass_pre && hb);
        keep = (cfg_strip == 2'd0) ? eff : ((eff >= 4) ? eff - 4 : 0);
        if (cfg_strip[1] && eff >= 14) begin
            ln = int'({body[12], body[13]});
            if (ln < 46 && 14 + ln < keep) keep = 14 + ln;
        end
        if (!(hb && !cfg_pass_pre)) begin
            if (cfg_pass_pre) for (int i = 0; i < 7; i++) lst.push_back(hdr_b[i]);
            for (int i = 0; i < keep; i++) lst.push_back(body[i]);
            for (int i = 0; i < lst.size(); i++) begin
                bit last;
                last = (i == lst.size() - 1) && keep > 0;
                exp_q.push_back({lst[i], i == 0, last, last && er, last && ov});
                req_q.push_back(req);
            end
        end
        k = 0;
        for (int i = 0; i < 7; i++) begin
            drive(hdr_b[i], i == 0, 1'b0, 1'b0);
            k++;
            if (gap > 0 && k % gap == 0) idle(1);
        end
        for (int i = 0; i < n; i++) begin
            drive(body[i], 1'b0, i == n - 1, fb && i == n - 1);
            k++;
            if (gap > 0 && k % gap == 0) idle(1);
        end
        idle(6);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d beats missing, expected 0", req, exp_q.size());
            exp_q.delete();
            req_q.delete();
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1: watchdog expired, actual hang, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid || out_sof || out_eof || out_err || out_oversize) begin
            fails++;
            $display("FAIL R11: flags during reset %b, expected 0",
                     {out_valid, out_sof, out_eof, out_err, out_oversize});
        end
        rst_n = 1'b1;
        idle(2);
        checks++;
        if (out_valid || out_eof || out_err) begin
            fails++;
            $display("FAIL R11: flags after reset %b, expected 0", {out_valid, out_eof, out_err});
        end

        // R1: plain delivery, no gaps and with gaps
        make_frame(60, 16'h0800); run_frame("R1", 0, 0);
        make_frame(64, 16'h0800); run_frame("R1", 0, 2);
        // R9: FCS bad without stripping
        make_frame(64, 16'h0800); run_frame("R9", 1, 0);

        // R2/R4: bad preamble dropped, next frame delivered
        cfg_strict_pre = 1'b1;
        make_frame(64, 16'h0800); hdr_b[3] = 8'h57; run_frame("R2", 0, 0);
        make_frame(64, 16'h0800); run_frame("R4", 0, 0);
        cfg_strict_pre = 1'b0;

        // R3: bad delimiter dropped when strict, delivered otherwise
        cfg_strict_sfd = 1'b1;
        make_frame(64, 16'h0800); hdr_b[6] = 8'hD4; run_frame("R3", 0, 1);
        cfg_strict_sfd = 1'b0;
        make_frame(64, 16'h0800); hdr_b[6] = 8'hD4; run_frame("R3", 0, 0);

        // R5: passthrough, good and with a failed strict check
        cfg_pass_pre = 1'b1;
        make_frame(64, 16'h0800); run_frame("R5", 0, 0);
        cfg_strict_pre = 1'b1;
        make_frame(64, 16'h0800); hdr_b[0] = 8'h54; run_frame("R5", 0, 3);
        cfg_strict_pre = 1'b0; cfg_pass_pre = 1'b0;

        // R6: oversize delivered whole
        cfg_max_len = 16'd64;
        make_frame(70, 16'h0800); run_frame("R6", 0, 0);
        // R7: truncation, and a body exactly at the limit
        cfg_trunc_en = 1'b1;
        make_frame(80, 16'h0800); run_frame("R7", 0, 2);
        make_frame(64, 16'h0800); run_frame("R7", 0, 0);
        // R8: truncation before FCS removal
        cfg_strip = 2'd1;
        make_frame(80, 16'h0800); run_frame("R8", 0, 0);
        cfg_trunc_en = 1'b0; cfg_max_len = 16'd1518;

        // R8: FCS removal, R9: error kept after removal
        make_frame(64, 16'h0800); run_frame("R8", 0, 0);
        make_frame(66, 16'h0800); run_frame("R9", 1, 2);

        // R10: pad removal with short length, zero length, and type value
        cfg_strip = 2'd2;
        make_frame(64, 16'd20); run_frame("R10", 0, 0);
        make_frame(64, 16'd0);  run_frame("R10", 1, 1);
        make_frame(70, 16'h0800); run_frame("R10", 0, 0);
        make_frame(64, 16'd46); run_frame("R10", 0, 0);
        cfg_strip = 2'd0;

        idle(4);
        done = 1;
        summary();
        $finish;
    end

endmodule